// File: doc/BRIEF.md
# Hypervisor debug control register

This block holds a 64-bit control word that a hypervisor uses to configure self-hosted debug and performance monitoring for the guest levels below it. It decides whether each system-register read or write to the word is permitted. The decision depends on the privilege level of the requester (0 to 3), a nested-virtualization trap bit, and the debug-access trap bit of the highest level. A permitted request is performed. A refused request is reported as undefined, or as a trap to level 2 or level 3 with syndrome 0x18. The result appears one cycle after the request.

Besides the raw stored word, the block drives an effective control word. Its fields are rewritten by the surrounding context: whether level 2 is enabled in the current security state, whether level 3 is present, the level-3 extended breakpoint enable, and the hypervisor trap-general flag. Consumers of the individual fields read the effective word. Direct reads always return the stored bits. Parameters select whether the step-op enable, the extended breakpoint enable and the PMU exception-enable field are implemented. A field that is not implemented is held at zero.

Top module: `hyp_dbg_ctrl`

## Requirements
- R1: Only bits 50, 43, 41:40, 36, 31:23, 19, 17 and 15:0 are storable. All other bits read as zero and ignore writes. With default parameters, writing all ones and reading back gives 64'h0004_0B10_FF8A_FFFF.
- R2: After reset the stored word is zero and no response is valid. Every request gives a response with rsp_valid high in the cycle after it, and only then.
- R3: A request at privilege level 0 gets result UNDEF (encoding 1), syndrome 0 and read data 0.
- R4: A request at level 1 gets TRAP2 (encoding 2) with syndrome 0x18 when nv_trap is 1, and UNDEF otherwise.
- R5: A request at level 2 gets TRAP3 (encoding 3) with syndrome 0x18 when el3_present and el3_dbg_trap are both 1. Otherwise it gets OK (encoding 0) with syndrome 0 and is performed. A request at level 3 always gets OK and is performed.
- R6: A refused request leaves the stored word unchanged and returns read data 0.
- R7: When el2_enabled is 0, the effective word has bit 50 = 1, bit 43 = 1 and bits 41:40 = 2'b01, while raw_value still shows the stored bits.
- R8: When el3_present is 1 and el3_ebwe is 0, effective bit 43 is 0, whatever el2_enabled is.
- R9: When tge is 1, effective bit 8 is 1.
- R10: When effective bit 8 is 1, effective bits 11:9 are all 1.
- R11: When effective bits 41:40 equal 2'b11, effective bit 26 is 1.
- R12: A permitted read returns the stored word on rsp_rdata. A write returns read data 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Access request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_priv | input | 2 | Privilege level of the requester |
| req_wdata | input | 64 | Write data |
| nv_trap | input | 1 | Nested-virtualization trap bit for level-1 access |
| el3_present | input | 1 | Level 3 is implemented |
| el3_dbg_trap | input | 1 | Level-3 debug-access trap bit |
| el3_ebwe | input | 1 | Level-3 extended breakpoint enable |
| el2_enabled | input | 1 | Level 2 enabled in the current security state |
| tge | input | 1 | Hypervisor trap-general flag |
| rsp_valid | output | 1 | Response strobe, one cycle after the request |
| rsp_result | output | 2 | 0 OK, 1 UNDEF, 2 TRAP2, 3 TRAP3 |
| rsp_syndrome | output | 6 | Trap syndrome (0x18 on trap, else 0) |
| rsp_rdata | output | 64 | Read data of a permitted read, else 0 |
| raw_value | output | 64 | Stored word |
| eff_ctrl | output | 64 | Effective control word, same bit positions |

## Verification
A write that updates the stored word can land in the same cycle that the context inputs change the overrides on the effective word. The bench raises tge at the same edge that a level-3 write clears the word. In the next cycle it checks that raw readback shows the new stored value while the effective routing bit and the three trap bits still come out forced. It also checks that a refused write issued after a permitted one leaves the earlier value visible on the following read.

// File: rtl/hdc_pkg.sv
package hdc_pkg;
  localparam int unsigned DATA_W = 64;
  localparam int unsigned SYN_W  = 6;
  localparam logic [SYN_W-1:0] SYN_SYSREG = 6'h18;

  localparam int unsigned B_STEPOP = 50;
  localparam int unsigned B_EXTBKP = 43;
  localparam int unsigned B_EXC_HI = 41;
  localparam int unsigned B_EXC_LO = 40;
  localparam int unsigned B_LONG   = 26;
  localparam int unsigned B_ROM    = 11;
  localparam int unsigned B_OSREG  = 10;
  localparam int unsigned B_DBGACC = 9;
  localparam int unsigned B_ROUTE  = 8;

  typedef enum logic [1:0] {
    ACC_OK    = 2'd0,
    ACC_UNDEF = 2'd1,
    ACC_TRAP2 = 2'd2,
    ACC_TRAP3 = 2'd3
  } acc_res_e;

  function automatic logic [DATA_W-1:0] store_mask(input logic has_step,
                                                   input logic has_ebw,
                                                   input logic has_exc);
    logic [DATA_W-1:0] m;
    m = '0;
    m[15:0]  = '1;
    m[17]    = 1'b1;
    m[19]    = 1'b1;
    m[31:23] = '1;
    m[36]    = 1'b1;
    m[B_EXC_HI:B_EXC_LO] = {2{has_exc}};
    m[B_EXTBKP] = has_ebw;
    m[B_STEPOP] = has_step;
    return m;
  endfunction
endpackage

// File: rtl/hdc_access_check.sv
module hdc_access_check
  import hdc_pkg::*;
(
  input  logic [1:0]       priv,
  input  logic             nv_trap,
  input  logic             el3_present,
  input  logic             el3_dbg_trap,
  output acc_res_e         result,
  output logic [SYN_W-1:0] syndrome
);
  always_comb begin
    result = ACC_UNDEF;
    unique case (priv)
      2'd0: result = ACC_UNDEF;
      2'd1: result = nv_trap ? ACC_TRAP2 : ACC_UNDEF;
      2'd2: result = (el3_present && el3_dbg_trap) ? ACC_TRAP3 : ACC_OK;
      default: result = ACC_OK;
    endcase
    syndrome = (result == ACC_TRAP2 || result == ACC_TRAP3) ? SYN_SYSREG : '0;
  end
endmodule

// File: rtl/hdc_store.sv
module hdc_store
  import hdc_pkg::*;
#(
  parameter logic [DATA_W-1:0] MASK = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] q
);
  logic [DATA_W-1:0] q_next;

  always_comb begin
    q_next = q;
    if (wr_en) q_next = wdata & MASK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_next;
  end

  assert_reserved_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (q & ~MASK) == '0);
endmodule

// File: rtl/hdc_effective.sv
module hdc_effective
  import hdc_pkg::*;
#(
  parameter logic [DATA_W-1:0] MASK = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] raw,
  input  logic              el2_enabled,
  input  logic              el3_present,
  input  logic              el3_ebwe,
  input  logic              tge,
  output logic [DATA_W-1:0] eff
);
  logic [DATA_W-1:0] e;

  always_comb begin
    e = raw;
    if (!el2_enabled) begin
      e[B_STEPOP] = 1'b1;
      e[B_EXTBKP] = 1'b1;
      e[B_EXC_HI:B_EXC_LO] = 2'b01;
    end
    if (el3_present && !el3_ebwe) e[B_EXTBKP] = 1'b0;
    if (tge) e[B_ROUTE] = 1'b1;
    if (e[B_ROUTE]) begin
      e[B_ROM]    = 1'b1;
      e[B_OSREG]  = 1'b1;
      e[B_DBGACC] = 1'b1;
    end
    if (e[B_EXC_HI:B_EXC_LO] == 2'b11) e[B_LONG] = 1'b1;
    eff = e & MASK;
  end

  assert_tge_route_R9: assert property (@(posedge clk) disable iff (!rst_n)
    tge |-> eff[B_ROUTE]);
  assert_route_traps_R10: assert property (@(posedge clk) disable iff (!rst_n)
    eff[B_ROUTE] |-> (eff[B_ROM:B_DBGACC] == 3'b111));
  assert_exc_long_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (eff[B_EXC_HI:B_EXC_LO] == 2'b11) |-> eff[B_LONG]);
  assert_el3_ebw_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (el3_present && !el3_ebwe) |-> !eff[B_EXTBKP]);
endmodule

// File: rtl/hyp_dbg_ctrl.sv
module hyp_dbg_ctrl
  import hdc_pkg::*;
#(
  parameter logic HAS_STEPOP   = 1'b1,
  parameter logic HAS_EXT_BKPT = 1'b1,
  parameter logic HAS_PMU_EXC  = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [1:0]        req_priv,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              nv_trap,
  input  logic              el3_present,
  input  logic              el3_dbg_trap,
  input  logic              el3_ebwe,
  input  logic              el2_enabled,
  input  logic              tge,
  output logic              rsp_valid,
  output logic [1:0]        rsp_result,
  output logic [SYN_W-1:0]  rsp_syndrome,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [DATA_W-1:0] raw_value,
  output logic [DATA_W-1:0] eff_ctrl
);
  localparam logic [DATA_W-1:0] MASK = store_mask(HAS_STEPOP, HAS_EXT_BKPT, HAS_PMU_EXC);

  acc_res_e          dec_res;
  logic [SYN_W-1:0]  dec_syn;
  logic              wr_en;
  logic [DATA_W-1:0] stored;

  logic              rsp_valid_d;
  logic [1:0]        rsp_result_d;
  logic [SYN_W-1:0]  rsp_syn_d;
  logic [DATA_W-1:0] rsp_rdata_d;

  hdc_access_check u_check (
    .priv         (req_priv),
    .nv_trap      (nv_trap),
    .el3_present  (el3_present),
    .el3_dbg_trap (el3_dbg_trap),
    .result       (dec_res),
    .syndrome     (dec_syn)
  );

  assign wr_en = req_valid && req_write && (dec_res == ACC_OK);

  hdc_store #(.MASK(MASK)) u_store (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (wr_en),
    .wdata (req_wdata),
    .q     (stored)
  );

  hdc_effective #(.MASK(MASK)) u_eff (
    .clk         (clk),
    .rst_n       (rst_n),
    .raw         (stored),
    .el2_enabled (el2_enabled),
    .el3_present (el3_present),
    .el3_ebwe    (el3_ebwe),
    .tge         (tge),
    .eff         (eff_ctrl)
  );

  always_comb begin
    rsp_valid_d  = req_valid;
    rsp_result_d = req_valid ? dec_res : ACC_OK;
    rsp_syn_d    = req_valid ? dec_syn : '0;
    rsp_rdata_d  = (req_valid && !req_write && dec_res == ACC_OK) ? stored : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid    <= 1'b0;
      rsp_result   <= ACC_OK;
      rsp_syndrome <= '0;
      rsp_rdata    <= '0;
    end else begin
      rsp_valid    <= rsp_valid_d;
      rsp_result   <= rsp_result_d;
      rsp_syndrome <= rsp_syn_d;
      rsp_rdata    <= rsp_rdata_d;
    end
  end

  assign raw_value = stored;

  assert_rsp_timing_R2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  assert_no_spurious_rsp_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);
  assert_el0_undef_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_priv == 2'd0) |=> (rsp_result == ACC_UNDEF && rsp_rdata == '0));
  assert_el1_trap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_priv == 2'd1 && nv_trap) |=> (rsp_result == ACC_TRAP2 && rsp_syndrome == SYN_SYSREG));
  assert_el3_ok_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_priv == 2'd3) |=> (rsp_result == ACC_OK));
  assert_reject_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && dec_res != ACC_OK) |=> $stable(raw_value));
endmodule

// File: tb/hyp_dbg_ctrl_tb.sv
module hyp_dbg_ctrl_tb_top;
  localparam int unsigned NVEC = 12;
  localparam logic [63:0] FULL = 64'h0004_0B10_FF8A_FFFF;

  typedef struct packed {
    logic [1:0]  priv;
    logic        wr;
    logic        nv;
    logic        e3p;
    logic        e3t;
    logic [63:0] wdata;
    logic [1:0]  exp_res;
    logic [63:0] exp_rdata;
  } vec_t;

  localparam vec_t VECS [NVEC] = '{
    '{2'd3, 1'b1, 1'b0, 1'b0, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF, 2'd0, 64'h0},
    '{2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 64'h0, 2'd0, FULL},
    '{2'd0, 1'b1, 1'b0, 1'b0, 1'b0, 64'h0, 2'd1, 64'h0},
    '{2'd0, 1'b0, 1'b1, 1'b0, 1'b0, 64'h0, 2'd1, 64'h0},
    '{2'd1, 1'b1, 1'b0, 1'b0, 1'b0, 64'h0, 2'd1, 64'h0},
    '{2'd1, 1'b0, 1'b1, 1'b0, 1'b0, 64'h0, 2'd2, 64'h0},
    '{2'd2, 1'b1, 1'b0, 1'b1, 1'b1, 64'h0, 2'd3, 64'h0},
    '{2'd2, 1'b0, 1'b0, 1'b1, 1'b0, 64'h0, 2'd0, FULL},
    '{2'd2, 1'b1, 1'b0, 1'b0, 1'b1, 64'h0000_0000_0000_0123, 2'd0, 64'h0},
    '{2'd3, 1'b0, 1'b0, 1'b1, 1'b1, 64'h0, 2'd0, 64'h0000_0000_0000_0123},
    '{2'd2, 1'b1, 1'b0, 1'b0, 1'b0, 64'h0000_0300_0000_0000, 2'd0, 64'h0},
    '{2'd2, 1'b0, 1'b0, 1'b0, 1'b0, 64'h0, 2'd0, 64'h0000_0300_0000_0000}
  };

  logic        clk, rst_n;
  logic        req_valid, req_write, nv_trap, el3_present, el3_dbg_trap, el3_ebwe, el2_enabled, tge;
  logic [1:0]  req_priv;
  logic [63:0] req_wdata;
  logic        rsp_valid;
  logic [1:0]  rsp_result;
  logic [5:0]  rsp_syndrome;
  logic [63:0] rsp_rdata, raw_value, eff_ctrl;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  hyp_dbg_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_priv(req_priv), .req_wdata(req_wdata), .nv_trap(nv_trap),
    .el3_present(el3_present), .el3_dbg_trap(el3_dbg_trap), .el3_ebwe(el3_ebwe),
    .el2_enabled(el2_enabled), .tge(tge), .rsp_valid(rsp_valid),
    .rsp_result(rsp_result), .rsp_syndrome(rsp_syndrome), .rsp_rdata(rsp_rdata),
    .raw_value(raw_value), .eff_ctrl(eff_ctrl)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic access(input logic [1:0] p, input logic w, input logic [63:0] d,
                        input logic nv, input logic e3p, input logic e3t);
    @(negedge clk);
    req_valid = 1'b1; req_write = w; req_priv = p; req_wdata = d;
    nv_trap = nv; el3_present = e3p; el3_dbg_trap = e3t;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_priv = 2'd0; req_wdata = '0;
    nv_trap = 1'b0; el3_present = 1'b0; el3_dbg_trap = 1'b0; el3_ebwe = 1'b1;
    el2_enabled = 1'b1; tge = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R2 reset rsp_valid", {63'h0, rsp_valid}, 64'h0);
    chk("R2 reset raw", raw_value, 64'h0);
    chk("R2 reset eff", eff_ctrl, 64'h0);

    for (int i = 0; i < NVEC; i++) begin
      vec_t v;
      v = VECS[i];
      access(v.priv, v.wr, v.wdata, v.nv, v.e3p, v.e3t);
      chk($sformatf("R2 vec%0d rsp_valid", i), {63'h0, rsp_valid}, 64'h1);
      chk($sformatf("R3 R4 R5 vec%0d result", i), {62'h0, rsp_result}, {62'h0, v.exp_res});
      chk($sformatf("R4 R5 vec%0d syndrome", i), {58'h0, rsp_syndrome},
          (v.exp_res >= 2'd2) ? 64'h18 : 64'h0);
      chk($sformatf("R1 R6 R12 vec%0d rdata", i), rsp_rdata, v.exp_rdata);
    end

    @(negedge clk);
    chk("R2 idle rsp_valid", {63'h0, rsp_valid}, 64'h0);

    el3_present = 1'b0; el2_enabled = 1'b1; tge = 1'b0; #1;
    chk("R11 long forced", eff_ctrl, 64'h0000_0300_0400_0000);
    el2_enabled = 1'b0; #1;
    chk("R7 el2 off eff", eff_ctrl, 64'h0004_0900_0000_0000);
    chk("R7 el2 off raw", raw_value, 64'h0000_0300_0000_0000);
    el3_present = 1'b1; el3_ebwe = 1'b0; #1;
    chk("R8 ebw cleared", eff_ctrl, 64'h0004_0100_0000_0000);
    el3_ebwe = 1'b1; #1;
    chk("R8 ebw kept", eff_ctrl, 64'h0004_0900_0000_0000);
    el3_present = 1'b0; el2_enabled = 1'b1; tge = 1'b1; #1;
    chk("R9 R10 tge forcing", eff_ctrl, 64'h0000_0300_0400_0F00);

    tge = 1'b0;
    access(2'd3, 1'b1, 64'h0000_0000_0000_0100, 1'b0, 1'b0, 1'b0);
    #1;
    chk("R10 stored route bit", eff_ctrl, 64'h0000_0000_0000_0F00);

    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_priv = 2'd3; req_wdata = 64'h0; tge = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R9 R12 same-cycle raw", raw_value, 64'h0);
    chk("R9 R10 same-cycle eff", eff_ctrl, 64'h0000_0000_0000_0F00);
    tge = 1'b0; #1;
    chk("R9 tge released", eff_ctrl, 64'h0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    #(20 * 20000);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule